// File: doc/BRIEF.md
# Key-Locked System Control Register Bank

This block is a bank of 32-bit system control words on a simple word-addressed bus with address, write enable, write data, read enable and read data. It holds the reset-control and clock-stop words of a chip, two strap words captured from pins at reset, revision and identity words, PLL configuration words and a random-number data port. Every access is a full aligned 32-bit word: the address counts words, not bytes.

Writes are guarded by a lock. Its state machine has two states. In `LK_CLOSED`, every write above word 0 is dropped. In `LK_OPEN`, those writes are accepted. The transition `KEY_MATCH` goes from `LK_CLOSED` to `LK_OPEN` on a write of the magic key to word 0. The transition `KEY_MISS` goes from `LK_OPEN` to `LK_CLOSED` on a write of any other value to word 0. The reset state comes from the `key_state_i` pin.

The control and strap words use a set/clear pair of addresses. A write to the base address ORs the data into the word. A write to the next address clears the bits that are 1 in the data. Each strap word has a protect word two addresses above its base. While the protect word is non-zero, set writes to that strap word are dropped.

Top module: `sysctl_keyed_bank`

## Requirements
- R1: Word 0 holds the lock state.
  - A write of exactly `KEY` (default 32'h1688A8A8) to word 0 makes word 0 read 1.
  - A write of any other value to word 0 makes it read 0.
  - Writes to word 0 are accepted whatever the lock state.
- R2: While word 0 reads 0, a write to any address above 0 changes no register.
- R3: The reset-control words at 0x04 and 0x06 and the clock-stop words at 0x08 and 0x0A are write-1-to-set. A write ORs the data into the stored word.
- R4: Each word at base+1 of a set/clear pair is a clear port. A write there clears, in the base word, every bit that is 1 in the data. A read of a clear port returns 0.
- R5: The strap words are at 0x10 and 0x14.
  - Each takes write-1-to-set writes at its base and write-1-to-clear writes at base+1.
  - Each has a read/write protect word at base+2 that resets to 0.
  - A set write is dropped while the protect word is non-zero. Clear writes still apply.
- R6: Writes are dropped at the read-only words. These are revision A at 0x01 (32'hA5A50001), revision B at 0x02, chip ID words at 0x2C (32'hC0DE0001) and 0x2D (32'hC0DE0002), and random data at 0x29.
- R7: The PLL extension words at 0x21, 0x23 and 0x25 are read/write and reset to 0. A read of one of them returns the stored value with bit 31 forced to 1. The PLL configuration words at 0x20, 0x22 and 0x24 read back unchanged.
- R8: A read of 0x29 returns the value of `rnd_i` in the read-strobe cycle. This holds whatever the RNG control word at 0x28 contains (read/write, reset 32'h00000001).
- R9: Reset values:
  - The strap words load `strap0_i` and `strap1_i`.
  - Revision B loads `rev_i`.
  - Word 0 loads `key_state_i`.
  - The remaining words load constants: 0x04 = 32'hFFFF0F0F, 0x06 = 32'h00FFFF00, 0x08 = 32'hF0F0A5A5, 0x0A = 32'h0F0F5A5A, 0x20 = 32'h00001234, 0x22 = 32'h00005678, 0x24 = 32'h00009ABC.
- R10: Addresses at or above `NUM_WORDS` (default 64) read 0, and writes there change no register. Unmapped addresses below `NUM_WORDS` also read 0 and ignore writes.
- R11: `rd_data_o` is registered.
  - It shows the addressed word one cycle after `rd_en_i`.
  - It holds its value in cycles without a read.
  - A read and a write to the same word in one cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Word address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |
| strap0_i | input | 32 | Reset value of strap word 0 |
| strap1_i | input | 32 | Reset value of strap word 1 |
| rev_i | input | 32 | Reset value of revision B |
| key_state_i | input | 1 | Reset state of the lock |
| rnd_i | input | 32 | Random source sampled on reads of 0x29 |

## Verification
The state hardest to reach from the ports is a frozen strap word that still takes clears. Reaching it takes three steps: open the lock with the key, write a non-zero protect word, then send a set write and a clear write to the same strap word. The stimulus does this in order and reads the strap word after each step, so that a dropped clear or a leaked set shows up in the read data. The other hard case is the lock closing again after a wrong key once it was open. It is reached by a bad-key write followed by a write to a control word that must not land.

// File: rtl/scb_pkg.sv
package scb_pkg;

    localparam int unsigned DATA_W    = 32;
    localparam int unsigned NUM_CTRL  = 4;
    localparam int unsigned NUM_STRAP = 2;
    localparam int unsigned NUM_SC    = NUM_CTRL + NUM_STRAP;
    localparam int unsigned NUM_PLAIN = 7;

    localparam int unsigned A_UNLOCK   = 'h00;
    localparam int unsigned A_REV_A    = 'h01;
    localparam int unsigned A_REV_B    = 'h02;
    localparam int unsigned A_RNG_DATA = 'h29;
    localparam int unsigned A_CHIP0    = 'h2C;
    localparam int unsigned A_CHIP1    = 'h2D;

    localparam logic [DATA_W-1:0] REV_A_VAL = 32'hA5A5_0001;
    localparam logic [DATA_W-1:0] CHIP0_VAL = 32'hC0DE_0001;
    localparam logic [DATA_W-1:0] CHIP1_VAL = 32'hC0DE_0002;
    localparam logic [DATA_W-1:0] LOCK_BIT  = 32'h8000_0000;

    typedef enum logic {
        LK_CLOSED = 1'b0,
        LK_OPEN   = 1'b1
    } lock_state_e;

    // Base address of set/clear pair k: control words first, then straps.
    function automatic int unsigned sc_base(int unsigned k);
        return (k < NUM_CTRL) ? (4 + 2 * k) : (16 + 4 * (k - NUM_CTRL));
    endfunction

    function automatic logic [DATA_W-1:0] sc_init(int unsigned k);
        case (k)
            0:       return 32'hFFFF_0F0F;
            1:       return 32'h00FF_FF00;
            2:       return 32'hF0F0_A5A5;
            3:       return 32'h0F0F_5A5A;
            default: return '0;
        endcase
    endfunction

    // Plain read/write words: PLL config/extension triples and RNG control.
    function automatic int unsigned plain_addr(int unsigned k);
        return (k < 6) ? ('h20 + k) : 'h28;
    endfunction

    function automatic logic [DATA_W-1:0] plain_init(int unsigned k);
        case (k)
            0:       return 32'h0000_1234;
            2:       return 32'h0000_5678;
            4:       return 32'h0000_9ABC;
            6:       return 32'h0000_0001;
            default: return '0;
        endcase
    endfunction

    function automatic logic is_pll_ext(int unsigned k);
        return (k < 6) && (k % 2 == 1);
    endfunction

endpackage

// File: rtl/scb_lock_fsm.sv
module scb_lock_fsm
    import scb_pkg::*;
#(
    parameter logic [DATA_W-1:0] KEY = 32'h1688A8A8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              key_state_i,
    input  logic              key_wr_i,
    input  logic [DATA_W-1:0] key_data_i,
    output logic              open_o
);

    lock_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= key_state_i ? LK_OPEN : LK_CLOSED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_CLOSED: if (key_wr_i && key_data_i == KEY) state_d = LK_OPEN;   // KEY_MATCH
            LK_OPEN:   if (key_wr_i && key_data_i != KEY) state_d = LK_CLOSED; // KEY_MISS
            default:   state_d = LK_CLOSED;
        endcase
    end

    always_comb begin
        open_o = (state_q == LK_OPEN);
    end

endmodule

// File: rtl/scb_setclr_reg.sv
module scb_setclr_reg
    import scb_pkg::*;
#(
    parameter bit HAS_PROTECT = 1'b0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] rst_val_i,
    input  logic              set_we_i,
    input  logic              clr_we_i,
    input  logic              protect_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] q_o
);

    logic set_ok;

    generate
        if (HAS_PROTECT) begin : g_prot
            assign set_ok = set_we_i && !protect_i;
        end else begin : g_noprot
            logic unused_prot;
            assign unused_prot = protect_i;
            assign set_ok      = set_we_i;
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q_o <= rst_val_i;
        end else if (set_ok) begin
            q_o <= q_o | data_i;
        end else if (clr_we_i) begin
            q_o <= q_o & ~data_i;
        end
    end

endmodule

// File: rtl/scb_plain_reg.sv
module scb_plain_reg
    import scb_pkg::*;
#(
    parameter logic [DATA_W-1:0] INIT = '0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] q_o
);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q_o <= INIT;
        end else if (we_i) begin
            q_o <= data_i;
        end
    end

endmodule

// File: rtl/sysctl_keyed_bank.sv
module sysctl_keyed_bank
    import scb_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 7,
    parameter int unsigned       NUM_WORDS = 64,
    parameter logic [DATA_W-1:0] KEY       = 32'h1688A8A8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [31:0]       wr_data_i,
    input  logic              rd_en_i,
    output logic [31:0]       rd_data_o,
    input  logic [31:0]       strap0_i,
    input  logic [31:0]       strap1_i,
    input  logic [31:0]       rev_i,
    input  logic              key_state_i,
    input  logic [31:0]       rnd_i
);

    logic              in_range;
    logic              lock_open;
    logic              key_wr;
    logic              wr_ok;
    logic [DATA_W-1:0] rev_b_q;
    logic [DATA_W-1:0] rd_next;
    logic [DATA_W-1:0] sc_q    [NUM_SC];
    logic [DATA_W-1:0] prot_q  [NUM_SC];
    logic [DATA_W-1:0] plain_q [NUM_PLAIN];

    assign in_range = (32'(addr_i) < NUM_WORDS);
    assign key_wr   = wr_en_i && (addr_i == ADDR_W'(A_UNLOCK));
    assign wr_ok    = wr_en_i && in_range && lock_open;

    scb_lock_fsm #(.KEY(KEY)) u_lock (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .key_state_i (key_state_i),
        .key_wr_i    (key_wr),
        .key_data_i  (wr_data_i),
        .open_o      (lock_open)
    );

    // Set/clear pairs; strap pairs also get a protect word at base+2.
    generate
        for (genvar k = 0; k < NUM_SC; k++) begin : g_sc
            logic              set_we, clr_we;
            logic [DATA_W-1:0] rst_val;

            assign set_we = wr_ok && (addr_i == ADDR_W'(sc_base(k)));
            assign clr_we = wr_ok && (addr_i == ADDR_W'(sc_base(k) + 1));

            if (k >= NUM_CTRL) begin : g_strap
                assign rst_val = (k == NUM_CTRL) ? strap0_i : strap1_i;
                scb_plain_reg #(.INIT('0)) u_prot (
                    .clk_i  (clk_i),
                    .rst_ni (rst_ni),
                    .we_i   (wr_ok && (addr_i == ADDR_W'(sc_base(k) + 2))),
                    .data_i (wr_data_i),
                    .q_o    (prot_q[k])
                );
            end else begin : g_ctrl
                assign rst_val   = sc_init(k);
                assign prot_q[k] = '0;
            end

            scb_setclr_reg #(.HAS_PROTECT(k >= NUM_CTRL)) u_reg (
                .clk_i     (clk_i),
                .rst_ni    (rst_ni),
                .rst_val_i (rst_val),
                .set_we_i  (set_we),
                .clr_we_i  (clr_we),
                .protect_i (prot_q[k] != '0),
                .data_i    (wr_data_i),
                .q_o       (sc_q[k])
            );
        end

        for (genvar p = 0; p < NUM_PLAIN; p++) begin : g_plain
            scb_plain_reg #(.INIT(plain_init(p))) u_reg (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .we_i   (wr_ok && (addr_i == ADDR_W'(plain_addr(p)))),
                .data_i (wr_data_i),
                .q_o    (plain_q[p])
            );
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rev_b_q <= rev_i;
        end else begin
            rev_b_q <= rev_b_q;
        end
    end

    always_comb begin
        rd_next = '0;
        if (in_range) begin
            if (addr_i == ADDR_W'(A_UNLOCK))   rd_next = {{(DATA_W-1){1'b0}}, lock_open};
            if (addr_i == ADDR_W'(A_REV_A))    rd_next = REV_A_VAL;
            if (addr_i == ADDR_W'(A_REV_B))    rd_next = rev_b_q;
            if (addr_i == ADDR_W'(A_CHIP0))    rd_next = CHIP0_VAL;
            if (addr_i == ADDR_W'(A_CHIP1))    rd_next = CHIP1_VAL;
            if (addr_i == ADDR_W'(A_RNG_DATA)) rd_next = rnd_i;
            for (int unsigned k = 0; k < NUM_SC; k++) begin
                if (addr_i == ADDR_W'(sc_base(k))) rd_next = sc_q[k];
                if (k >= NUM_CTRL && addr_i == ADDR_W'(sc_base(k) + 2)) rd_next = prot_q[k];
            end
            for (int unsigned p = 0; p < NUM_PLAIN; p++) begin
                if (addr_i == ADDR_W'(plain_addr(p)))
                    rd_next = plain_q[p] | (is_pll_ext(p) ? LOCK_BIT : '0);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rd_data_o <= '0;
        end else if (rd_en_i) begin
            rd_data_o <= rd_next;
        end
    end

endmodule

// File: rtl/sysctl_keyed_bank_chk.sv
module sysctl_keyed_bank_chk #(
    parameter int unsigned ADDR_W    = 7,
    parameter int unsigned NUM_WORDS = 64,
    parameter logic [31:0] KEY       = 32'h1688A8A8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_en_i,
    input logic [31:0]       wr_data_i,
    input logic              rd_en_i,
    input logic [31:0]       rd_data_o,
    input logic [31:0]       rnd_i,
    input logic              lock_open,
    input logic [31:0]       ctrl0_q
);

    a_r1_key_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == '0 && wr_data_i == KEY) |=> lock_open);

    a_r1_bad_key_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == '0 && wr_data_i != KEY) |=> !lock_open);

    a_r2_locked_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!lock_open && wr_en_i && addr_i == ADDR_W'(4)) |=> $stable(ctrl0_q));

    a_r7_pll_lock_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && addr_i == ADDR_W'('h21)) |=> rd_data_o[31]);

    a_r8_rng_fresh: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && addr_i == ADDR_W'('h29)) |=> (rd_data_o == $past(rnd_i)));

    a_r10_out_of_range_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && 32'(addr_i) >= NUM_WORDS) |=> (rd_data_o == '0));

    a_r11_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> $stable(rd_data_o));

endmodule

bind sysctl_keyed_bank sysctl_keyed_bank_chk #(
    .ADDR_W    (ADDR_W),
    .NUM_WORDS (NUM_WORDS),
    .KEY       (KEY)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_en_i   (rd_en_i),
    .rd_data_o (rd_data_o),
    .rnd_i     (rnd_i),
    .lock_open (lock_open),
    .ctrl0_q   (sc_q[0])
);

// File: tb/sysctl_keyed_bank_bench.sv
module sysctl_keyed_bank_bench;

    localparam logic [31:0] KEY    = 32'h1688A8A8;
    localparam logic [31:0] STRAP0 = 32'h1111_0000;
    localparam logic [31:0] STRAP1 = 32'h0000_2222;
    localparam logic [31:0] REV    = 32'h0000_00B7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic [31:0] rnd = '0;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] last_exp = '0;

    always #4 clk = ~clk;

    sysctl_keyed_bank u_sysctl_keyed_bank (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .addr_i      (addr),
        .wr_en_i     (wr_en),
        .wr_data_i   (wr_data),
        .rd_en_i     (rd_en),
        .rd_data_o   (rd_data),
        .strap0_i    (STRAP0),
        .strap1_i    (STRAP1),
        .rev_i       (REV),
        .key_state_i (1'b0),
        .rnd_i       (rnd)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, input logic [31:0] exp, input string tag,
                      input logic [31:0] r = 32'h0);
        @(negedge clk);
        addr = a; rd_en = 1'b1; rnd = r;
        exp_q.push_back(exp); tag_q.push_back(tag); last_exp = exp;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wrrd(input logic [6:0] a, input logic [31:0] d, input logic [31:0] exp,
                        input string tag);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1; rd_en = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag); last_exp = exp;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    // Monitor: a read seen at a rising edge is compared at the following falling edge.
    initial begin
        forever begin
            logic took;
            @(posedge clk);
            took = rd_en;
            @(negedge clk);
            if (took) begin
                if (exp_q.size() == 0) begin
                    check(rd_data, 32'hx, "scoreboard underflow");
                end else begin
                    check(rd_data, exp_q.pop_front(), tag_q.pop_front());
                end
            end
        end
    end

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset values
        rd(7'h00, 32'h0, "R9 lock from key_state");
        rd(7'h10, STRAP0, "R9 strap0");
        rd(7'h14, STRAP1, "R9 strap1");
        rd(7'h02, REV, "R9 revision B");
        rd(7'h04, 32'hFFFF_0F0F, "R9 ctrl 0x04");
        rd(7'h0A, 32'h0F0F_5A5A, "R9 ctrl 0x0A");
        rd(7'h24, 32'h0000_9ABC, "R9 pll cfg 0x24");

        // R2 locked writes dropped
        wr(7'h04, 32'hFFFF_FFFF);
        wr(7'h20, 32'h0);
        rd(7'h04, 32'hFFFF_0F0F, "R2 locked set");
        rd(7'h20, 32'h0000_1234, "R2 locked plain");

        // R1 key handling
        wr(7'h00, 32'h0000_1234);
        rd(7'h00, 32'h0, "R1 wrong key");
        wr(7'h00, KEY);
        rd(7'h00, 32'h1, "R1 key opens");

        // R3 / R4 set and clear ports
        wr(7'h04, 32'h0000_00F0);
        rd(7'h04, 32'hFFFF_0FFF, "R3 ctrl set");
        wr(7'h05, 32'hFF00_0000);
        rd(7'h04, 32'h00FF_0FFF, "R4 ctrl clear");
        wr(7'h08, 32'h0F00_0000);
        rd(7'h08, 32'hFFF0_A5A5, "R3 clkstop set");
        wr(7'h09, 32'h0000_00A5);
        rd(7'h08, 32'hFFF0_A500, "R4 clkstop clear");
        rd(7'h09, 32'h0, "R4 clear port reads 0");

        // R5 strap with protect
        wr(7'h10, 32'h0000_000F);
        rd(7'h10, 32'h1111_000F, "R5 strap set");
        wr(7'h11, 32'h1000_0000);
        rd(7'h10, 32'h0111_000F, "R5 strap clear");
        wr(7'h12, 32'h0000_0001);
        rd(7'h12, 32'h0000_0001, "R5 protect readback");
        wr(7'h10, 32'hF000_0000);
        rd(7'h10, 32'h0111_000F, "R5 protected set dropped");
        wr(7'h11, 32'h0000_0001);
        rd(7'h10, 32'h0111_000E, "R5 protected clear applies");
        wr(7'h14, 32'h0000_0001);
        rd(7'h14, 32'h0000_2223, "R5 strap1 unprotected set");

        // R6 read-only words
        wr(7'h02, 32'hFFFF_FFFF);
        rd(7'h02, REV, "R6 revision B");
        wr(7'h01, 32'h0);
        rd(7'h01, 32'hA5A5_0001, "R6 revision A");
        wr(7'h2C, 32'h0);
        rd(7'h2C, 32'hC0DE_0001, "R6 chip id 0");
        wr(7'h2D, 32'h0);
        rd(7'h2D, 32'hC0DE_0002, "R6 chip id 1");

        // R7 PLL lock bit
        rd(7'h21, 32'h8000_0000, "R7 ext reset");
        wr(7'h21, 32'h0000_0055);
        rd(7'h21, 32'h8000_0055, "R7 ext 0x21");
        wr(7'h23, 32'h0000_0ABC);
        rd(7'h23, 32'h8000_0ABC, "R7 ext 0x23");
        rd(7'h25, 32'h8000_0000, "R7 ext 0x25");
        wr(7'h20, 32'h0000_0042);
        rd(7'h20, 32'h0000_0042, "R7 cfg no forcing");

        // R8 random data
        rd(7'h28, 32'h0000_0001, "R8 rng ctrl reset");
        rd(7'h29, 32'hDEAD_BEEF, "R8 rng first", 32'hDEAD_BEEF);
        wr(7'h28, 32'h0);
        rd(7'h29, 32'h1357_2468, "R8 rng with enable cleared", 32'h1357_2468);
        wr(7'h29, 32'hFFFF_FFFF);
        rd(7'h29, 32'h0BAD_F00D, "R6 R8 rng write dropped", 32'h0BAD_F00D);

        // R10 range handling
        rd(7'h40, 32'h0, "R10 out of range read");
        wr(7'h44, 32'hFFFF_FFFF);
        rd(7'h04, 32'h00FF_0FFF, "R10 out of range write");
        wr(7'h30, 32'hFFFF_FFFF);
        rd(7'h30, 32'h0, "R10 unmapped in range");

        // R11 timing
        wrrd(7'h06, 32'h0000_0001, 32'h00FF_FF00, "R11 same-cycle old value");
        rd(7'h06, 32'h00FF_FF01, "R11 write landed");
        repeat (3) @(negedge clk);
        check(rd_data, last_exp, "R11 hold when idle");

        // R1 / R2 relock
        wr(7'h00, 32'h0);
        rd(7'h00, 32'h0, "R1 relock");
        wr(7'h06, 32'hFFFF_FFFF);
        rd(7'h06, 32'h00FF_FF01, "R2 write after relock");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) check(32'(exp_q.size()), 32'h0, "scoreboard leftover");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule